// File: doc/BRIEF.md
# Wired-OR Transfer Bus Register Set

This block holds a small group of equal-width working registers that all exchange data over a single shared transfer bus. Each register takes three per-step strobes from a sequencer: a zeroing strobe, a load strobe that lets 1-bits on the bus set matching register bits, and a drive strobe that places the register onto the bus. Units outside the set can also place a word on the bus through a side input.

The bus is the bitwise OR of everything driving it in that step. Driving two registers at once therefore produces their OR without any logic unit. One register, the complement-capable one, also has a second drive strobe that places the inverse of its contents on the bus. A sequencer can build AND and other Boolean results from inversion and OR alone. A full load is a zeroing step followed by a load step. A load without a prior zeroing step merges the bus into the old contents.

The bus is combinational from the current register contents. A register can therefore be driven and another loaded in the same step, and the move completes at the next rising edge. The block has no state machine: every register is a simple edge-sampled word.

Top module: `wbus_regset`

## Requirements
- R1: After reset every register holds zero, so driving any of them alone gives an all-zero bus.
- R2: With no drive strobe active and the side input at zero, the bus is all zeros.
- R3: While a register's drive strobe (`rd_stb[i]`, bit i selects register i) is high, its stored word appears on the bus in that same step.
- R4: When several sources drive in one step, the bus equals the bitwise OR of all of them, including the side input `src_i`.
- R5: While `rd_cmp_stb` is high, the bus carries the bitwise inverse of register `CMP_IDX` (default 3), ORed with any other active sources.
- R6: A zeroing strobe `clr_stb[i]` sampled at a rising edge leaves register i at zero after that edge.
- R7: A load strobe `wr_stb[i]` without a zeroing strobe sets register i to its old value ORed with the bus value of that step.
- R8: When zeroing and load strobes for one register are both high at an edge, the zeroing wins and the register becomes zero.
- R9: A register with neither zeroing nor load strobe keeps its value across edges.
- R10: A drive of register j together with a load of a previously zeroed register k in one step copies j into k at the next edge.
- R11: AND of two registers is obtained by inverting each through the complement-capable register, ORing the inverses on the bus and inverting the result once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, zeroes all registers |
| clr_stb | input | NREG | Per-register zeroing strobe |
| wr_stb | input | NREG | Per-register load-from-bus strobe |
| rd_stb | input | NREG | Per-register drive-onto-bus strobe |
| rd_cmp_stb | input | 1 | Drive the inverse of register CMP_IDX onto the bus |
| src_i | input | WIDTH | Word placed on the bus by units outside the set; zero when idle |
| bus_o | output | WIDTH | Current value of the shared transfer bus |

## Verification
Single-source drives with distinct per-register patterns show that each strobe selects its own register and no other. Two- and three-way drives with overlapping and disjoint bit patterns, and the inverted drive mixed with a plain one, separate a true OR from a priority mux or an AND. Loads with and without a prior zeroing step, and a zeroing and load on the same edge, separate merge, replace and priority behaviour. A register-only AND of two overlapping words confirms that the inversion and OR paths compose correctly.

// File: rtl/wbus_pkg.sv
package wbus_pkg;
    localparam int unsigned WBUS_WIDTH_DEF = 16;
    localparam int unsigned WBUS_NREG_DEF  = 4;
    localparam int unsigned WBUS_CMP_DEF   = 3;
endpackage

// File: rtl/wbus_cell.sv
module wbus_cell #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] val_o
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clr_i) begin
            word_q <= '0;
        end else if (wr_i) begin
            word_q <= word_q | bus_i;
        end
    end

    assign val_o = word_q;

    // R6 and R8: zeroing wins at the edge
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_o == '0));

    // R7: load merges the bus into old contents
    assert_merge_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (((val_o & $past(bus_i)) == $past(bus_i)) &&
                              ((val_o & $past(val_o)) == $past(val_o))));

    // R9: hold with no strobe
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> $stable(val_o));
endmodule

// File: rtl/wbus_drive.sv
module wbus_drive #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             rd_i,
    input  logic             rdc_i,
    output logic [WIDTH-1:0] drv_o
);
    always_comb begin
        drv_o = '0;
        if (rd_i)  drv_o = drv_o | val_i;
        if (rdc_i) drv_o = drv_o | ~val_i;
    end
endmodule

// File: rtl/wbus_merge.sv
module wbus_merge #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NSRC  = 5
) (
    input  logic [NSRC-1:0][WIDTH-1:0] drv_i,
    output logic [WIDTH-1:0]           bus_o
);
    always_comb begin
        bus_o = '0;
        for (int s = 0; s < NSRC; s++) begin
            bus_o = bus_o | drv_i[s];
        end
    end
endmodule

// File: rtl/wbus_regset.sv
module wbus_regset #(
    parameter int unsigned WIDTH   = wbus_pkg::WBUS_WIDTH_DEF,
    parameter int unsigned NREG    = wbus_pkg::WBUS_NREG_DEF,
    parameter int unsigned CMP_IDX = wbus_pkg::WBUS_CMP_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  clr_stb,
    input  logic [NREG-1:0]  wr_stb,
    input  logic [NREG-1:0]  rd_stb,
    input  logic             rd_cmp_stb,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] bus_o
);
    localparam int unsigned NSRC = NREG + 1;

    logic [NREG-1:0][WIDTH-1:0] cell_val;
    logic [NSRC-1:0][WIDTH-1:0] drv;
    logic [WIDTH-1:0]           bus;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic rdc;
        if (i == CMP_IDX) begin : g_cmp
            assign rdc = rd_cmp_stb;
        end else begin : g_plain
            assign rdc = 1'b0;
        end

        wbus_cell #(.WIDTH(WIDTH)) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_stb[i]),
            .wr_i  (wr_stb[i]),
            .bus_i (bus),
            .val_o (cell_val[i])
        );

        wbus_drive #(.WIDTH(WIDTH)) drive_i (
            .val_i (cell_val[i]),
            .rd_i  (rd_stb[i]),
            .rdc_i (rdc),
            .drv_o (drv[i])
        );

        // R3 and R4: every driving register is contained in the bus
        assert_rd_in_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb[i] |-> ((bus & cell_val[i]) == cell_val[i]));
    end

    assign drv[NREG] = src_i;

    wbus_merge #(.WIDTH(WIDTH), .NSRC(NSRC)) merge_i (
        .drv_i (drv),
        .bus_o (bus)
    );

    assign bus_o = bus;

    // R2: quiet bus
    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb == '0) && !rd_cmp_stb && (src_i == '0)) |-> (bus_o == '0));

    // R5: inverse drive contained in the bus
    assert_cmp_in_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmp_stb |-> ((bus & ~cell_val[CMP_IDX]) == ~cell_val[CMP_IDX]));

    // R4: external source contained in the bus
    assert_src_in_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_o & src_i) == src_i));
endmodule

// File: tb/wbus_regset_tb_top.sv
`timescale 1ns/1ps
module wbus_regset_tb_top;
    localparam int W  = 16;
    localparam int N  = 4;
    localparam int CB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0] clr = '0, wr = '0, rd = '0;
    logic         rdc = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] bus;

    wbus_regset #(.WIDTH(W), .NREG(N), .CMP_IDX(CB)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_stb(clr), .wr_stb(wr), .rd_stb(rd),
        .rd_cmp_stb(rdc), .src_i(src), .bus_o(bus)
    );

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
        bit           chk;
    } item_t;

    item_t        sb_q[$];
    logic [W-1:0] m [N];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: apply one step, push the expected bus, update the model
    task automatic step(input logic [N-1:0] c, input logic [N-1:0] w,
                        input logic [N-1:0] r, input logic rc,
                        input logic [W-1:0] s, input string tag, input bit chk);
        logic [W-1:0] e;
        item_t it;
        @(negedge clk);
        clr = c; wr = w; rd = r; rdc = rc; src = s;
        e = s;
        for (int i = 0; i < N; i++) if (r[i]) e = e | m[i];
        if (rc) e = e | ~m[CB];
        it.exp = e; it.tag = tag; it.chk = chk;
        sb_q.push_back(it);
        for (int i = 0; i < N; i++) begin
            if (c[i]) m[i] = '0;
            else if (w[i]) m[i] = m[i] | e;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step('0, '0, '0, 1'b0, '0, "idle", 0);
    endtask

    task automatic load(input int idx, input logic [W-1:0] v);
        step(N'(1) << idx, '0, '0, 1'b0, '0, "load", 0);
        step('0, N'(1) << idx, '0, 1'b0, v, "load", 0);
    endtask

    task automatic peek(input int idx, input string tag);
        step('0, '0, N'(1) << idx, 1'b0, '0, tag, 1);
    endtask

    // monitor: pop and compare away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (it.chk) begin
                    checks++;
                    if (bus !== it.exp) begin
                        errors++;
                        $display("FAIL %s: bus=%h expected=%h", it.tag, bus, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 quiet bus
        for (int i = 0; i < N; i++) peek(i, "R1 reset");
        step('0, '0, '0, 1'b0, '0, "R2 quiet", 1);

        // R3 single drives
        load(0, 16'h1234);
        load(1, 16'h00F0);
        load(2, 16'hA005);
        load(3, 16'h0F0F);
        for (int i = 0; i < N; i++) peek(i, "R3 single");

        // R4 OR of multiple sources
        step('0, '0, 4'b0011, 1'b0, '0, "R4 two", 1);
        step('0, '0, 4'b0111, 1'b0, 16'h8000, "R4 three+src", 1);

        // R5 inverse drive, alone and mixed
        step('0, '0, '0, 1'b1, '0, "R5 inv", 1);
        step('0, '0, 4'b0001, 1'b1, '0, "R5 inv+A", 1);

        // R7 load without zeroing merges
        step('0, 4'b0010, '0, 1'b0, 16'h0F00, "R7 merge", 0);
        peek(1, "R7 merged");

        // R6 zeroing
        step(4'b0010, '0, '0, 1'b0, '0, "R6 clr", 0);
        peek(1, "R6 zero");

        // R8 zeroing beats load
        step(4'b0100, 4'b0100, '0, 1'b0, 16'hFFFF, "R8 both", 0);
        peek(2, "R8 zero");

        // R9 hold
        idle(5);
        peek(0, "R9 hold");
        peek(3, "R9 hold");

        // R10 register to register transfer
        step(4'b0100, '0, '0, 1'b0, '0, "R10 prep", 0);
        step('0, 4'b0100, 4'b0001, 1'b0, '0, "R10 move", 1);
        peek(2, "R10 copy");

        // R11 AND of A and Q via inversion
        load(0, 16'hC3A5);
        load(1, 16'h5AF0);
        step(4'b1000, '0, '0, 1'b0, '0, "R11", 0);
        step('0, 4'b1000, 4'b0001, 1'b0, '0, "R11", 0);
        step(4'b0100, '0, '0, 1'b0, '0, "R11", 0);
        step('0, 4'b0100, '0, 1'b1, '0, "R11", 0);
        step(4'b1000, '0, '0, 1'b0, '0, "R11", 0);
        step('0, 4'b1000, 4'b0010, 1'b0, '0, "R11", 0);
        step(4'b0010, '0, '0, 1'b0, '0, "R11", 0);
        step('0, 4'b0010, 4'b0100, 1'b1, '0, "R11", 0);
        step(4'b1000, '0, '0, 1'b0, '0, "R11", 0);
        step('0, 4'b1000, 4'b0010, 1'b0, '0, "R11", 0);
        step('0, '0, '0, 1'b1, '0, "R11 and", 1);
        // independent constant check of the AND result
        @(negedge clk);
        #1;
        checks++;
        if (bus !== (16'hC3A5 & 16'h5AF0)) begin
            errors++;
            $display("FAIL R11 const: bus=%h expected=%h", bus, 16'hC3A5 & 16'h5AF0);
        end
        idle(3);
        summary();
    end
endmodule